// File: doc/BRIEF.md
# Dual-Bank Operand Store with Fast Slot

This block keeps a handful of operand values close to two operand register sets, A and B. It has two banks of small cells, and each bank has its own read port. Bank A supplies only register set A and bank B supplies only register set B, so both sets can be loaded in the same cycle from independent cell indexes. One shared write-data bus can store a value into bank A, into bank B, or into both at once. Each bank takes its own write index, so one value can land in different cells of the two banks.

A separate single-entry fast slot holds a value that is used over and over, such as a fixed step added on every pass. It is loaded from the same write bus. Its content reaches the outputs with no added read delay. A per-set routing select puts the fast value on either operand output, or on both, in place of that set's bank read.

Bank reads are registered. A read index presented at one clock edge shows its cell on the output after that edge. A fast-slot write is also captured at a clock edge, and its value appears on any routed output straight after that edge.

Top module: `opc_dual_store`

## Requirements
- R1: A synchronous active-high reset clears every cell, both bank read registers and the fast slot, so both operand outputs read 0 after reset.
- R2: `wr_en_a` and `wr_en_b` choose the target of a write independently: bank A only, bank B only, or both in the same cycle. A bank whose enable is low is left unchanged.
- R3: When both banks are written in one cycle, bank A stores `wr_data` at `wr_idx_a` and bank B stores it at `wr_idx_b`, and the two indexes may differ.
- R4: Both banks are read in every cycle, each at its own index (`rd_idx_a`, `rd_idx_b`). The cell selected at a clock edge appears on the bank's output after that edge, which is one cycle of latency.
- R5: With the default of 3 cells per bank, a cell index equal to 3 is out of range. A write at index 3 changes no cell, and a read at index 3 returns 0.
- R6: When a cell is written and read at the same clock edge, the read returns the value the cell held before that write.
- R7: When `fast_we` is high at a clock edge, `wr_data` is stored in the fast slot. After that edge the stored value is on every output whose route select is high, with no further cycle of delay.
- R8: `fast_to_a` = 1 replaces `opnd_a` with the fast-slot value, and `fast_to_b` = 1 does the same for `opnd_b`. The effect is combinational in the same cycle, and both may be high together. A route select does not change the bank read register: clearing the select shows the bank value again.
- R9: With its route select low, each output shows its own bank's read register and never the other bank's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | DW (8) | Shared write-data bus for both banks and the fast slot |
| wr_en_a | input | 1 | Write enable for bank A |
| wr_en_b | input | 1 | Write enable for bank B |
| wr_idx_a | input | IW (2) | Write cell index for bank A |
| wr_idx_b | input | IW (2) | Write cell index for bank B |
| rd_idx_a | input | IW (2) | Read cell index for bank A |
| rd_idx_b | input | IW (2) | Read cell index for bank B |
| fast_we | input | 1 | Load the fast slot from `wr_data` |
| fast_to_a | input | 1 | Route the fast slot to operand A |
| fast_to_b | input | 1 | Route the fast slot to operand B |
| opnd_a | output | DW (8) | Operand for register set A |
| opnd_b | output | DW (8) | Operand for register set B |

## Verification
The bench builds the block with its default parameters: 8-bit data, 3 cells per bank and a 2-bit index. With these values the 2-bit index can still encode 3, so the out-of-range value is reachable and random indexes hit it about one time in four, for writes as well as reads. The small cell count also makes same-cell write-and-read collisions and dual-bank writes at differing indexes frequent under random stimulus. Directed steps pin down the reset state and the combinational switching of the route selects.

// File: rtl/opc_pkg.sv
package opc_pkg;
    localparam int OPC_DW    = 8;
    localparam int OPC_CELLS = 3;
    localparam int OPC_BANKS = 2;

    typedef enum logic {
        SRC_BANK = 1'b0,
        SRC_FAST = 1'b1
    } opc_src_e;
endpackage

// File: rtl/opc_bank.sv
module opc_bank #(
    parameter int DW    = 8,
    parameter int CELLS = 3,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] cell_q [CELLS];
    logic [DW-1:0] rd_sel;

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cell_q[c] <= '0;
            else if (wr_en && (wr_idx == IW'(c)))
                cell_q[c] <= wr_data;
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int c = 0; c < CELLS; c++) begin
            if (rd_idx == IW'(c))
                rd_sel = cell_q[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= rd_sel;
    end
endmodule

// File: rtl/opc_fast_slot.sv
module opc_fast_slot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/opc_route.sv
module opc_route
    import opc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          fast_sel,
    input  logic [DW-1:0] bank_q,
    input  logic [DW-1:0] fast_q,
    output logic [DW-1:0] opnd
);
    opc_src_e src;

    always_comb begin
        src = fast_sel ? SRC_FAST : SRC_BANK;
        unique case (src)
            SRC_FAST: opnd = fast_q;
            SRC_BANK: opnd = bank_q;
            default:  opnd = bank_q;
        endcase
    end
endmodule

// File: rtl/opc_dual_store.sv
module opc_dual_store
    import opc_pkg::*;
#(
    parameter int DW    = OPC_DW,
    parameter int CELLS = OPC_CELLS,
    parameter int IW    = $clog2(CELLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en_a,
    input  logic          wr_en_b,
    input  logic [IW-1:0] wr_idx_a,
    input  logic [IW-1:0] wr_idx_b,
    input  logic [IW-1:0] rd_idx_a,
    input  logic [IW-1:0] rd_idx_b,
    input  logic          fast_we,
    input  logic          fast_to_a,
    input  logic          fast_to_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    localparam int NB = OPC_BANKS;

    logic          bank_we  [NB];
    logic [IW-1:0] bank_wi  [NB];
    logic [IW-1:0] bank_ri  [NB];
    logic          bank_fs  [NB];
    logic [DW-1:0] bank_q   [NB];
    logic [DW-1:0] bank_out [NB];
    logic [DW-1:0] fast_q;

    assign bank_we[0] = wr_en_a;
    assign bank_we[1] = wr_en_b;
    assign bank_wi[0] = wr_idx_a;
    assign bank_wi[1] = wr_idx_b;
    assign bank_ri[0] = rd_idx_a;
    assign bank_ri[1] = rd_idx_b;
    assign bank_fs[0] = fast_to_a;
    assign bank_fs[1] = fast_to_b;

    opc_fast_slot #(.DW(DW)) u_fast (
        .clk (clk),
        .rst (rst),
        .we  (fast_we),
        .d   (wr_data),
        .q   (fast_q)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        opc_bank #(.DW(DW), .CELLS(CELLS), .IW(IW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_data (wr_data),
            .wr_en   (bank_we[b]),
            .wr_idx  (bank_wi[b]),
            .rd_idx  (bank_ri[b]),
            .rd_q    (bank_q[b])
        );

        opc_route #(.DW(DW)) u_route (
            .fast_sel (bank_fs[b]),
            .bank_q   (bank_q[b]),
            .fast_q   (fast_q),
            .opnd     (bank_out[b])
        );
    end

    assign opnd_a = bank_out[0];
    assign opnd_b = bank_out[1];
endmodule

// File: rtl/opc_dual_store_chk.sv
module opc_dual_store_chk #(
    parameter int DW    = 8,
    parameter int CELLS = 3,
    parameter int IW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] wr_data,
    input logic          wr_en_a,
    input logic          wr_en_b,
    input logic [IW-1:0] wr_idx_a,
    input logic [IW-1:0] wr_idx_b,
    input logic [IW-1:0] rd_idx_a,
    input logic [IW-1:0] rd_idx_b,
    input logic          fast_we,
    input logic          fast_to_a,
    input logic          fast_to_b,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b
);
    logic [DW-1:0] sh_a [CELLS];
    logic [DW-1:0] sh_b [CELLS];
    logic [DW-1:0] exp_a, exp_b, exp_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < CELLS; c++) begin
                sh_a[c] <= '0;
                sh_b[c] <= '0;
            end
            exp_a <= '0;
            exp_b <= '0;
            exp_f <= '0;
        end else begin
            exp_a <= '0;
            exp_b <= '0;
            for (int c = 0; c < CELLS; c++) begin
                if (rd_idx_a == IW'(c)) exp_a <= sh_a[c];
                if (rd_idx_b == IW'(c)) exp_b <= sh_b[c];
                if (wr_en_a && wr_idx_a == IW'(c)) sh_a[c] <= wr_data;
                if (wr_en_b && wr_idx_b == IW'(c)) sh_b[c] <= wr_data;
            end
            if (fast_we) exp_f <= wr_data;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (opnd_a == '0 && opnd_b == '0));

    p_bank_a_read_r4: assert property (@(posedge clk) disable iff (rst)
        !fast_to_a |-> opnd_a == exp_a);

    p_bank_b_read_r9: assert property (@(posedge clk) disable iff (rst)
        !fast_to_b |-> opnd_b == exp_b);

    p_fast_to_a_r7: assert property (@(posedge clk) disable iff (rst)
        fast_to_a |-> opnd_a == exp_f);

    p_fast_to_b_r8: assert property (@(posedge clk) disable iff (rst)
        fast_to_b |-> opnd_b == exp_f);

    p_fast_both_r8: assert property (@(posedge clk) disable iff (rst)
        (fast_to_a && fast_to_b) |-> opnd_a == opnd_b);
endmodule

bind opc_dual_store opc_dual_store_chk #(.DW(DW), .CELLS(CELLS), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (wr_data),
    .wr_en_a   (wr_en_a),
    .wr_en_b   (wr_en_b),
    .wr_idx_a  (wr_idx_a),
    .wr_idx_b  (wr_idx_b),
    .rd_idx_a  (rd_idx_a),
    .rd_idx_b  (rd_idx_b),
    .fast_we   (fast_we),
    .fast_to_a (fast_to_a),
    .fast_to_b (fast_to_b),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b)
);

// File: tb/tb_opc_dual_store.sv
module tb_opc_dual_store;
    localparam int DW = 8;
    localparam int CELLS = 3;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic wr_en_a = 0, wr_en_b = 0, fast_we = 0, fast_to_a = 0, fast_to_b = 0;
    logic [IW-1:0] wr_idx_a = '0, wr_idx_b = '0, rd_idx_a = '0, rd_idx_b = '0;
    logic [DW-1:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] ma [CELLS];
    logic [DW-1:0] mb [CELLS];
    logic [DW-1:0] mq_a = '0, mq_b = '0, mf = '0;

    always #10 clk = ~clk;

    opc_dual_store #(.DW(DW), .CELLS(CELLS), .IW(IW)) dut (
        .clk(clk), .rst(rst), .wr_data(wr_data),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
        .wr_idx_a(wr_idx_a), .wr_idx_b(wr_idx_b),
        .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
        .fast_we(fast_we), .fast_to_a(fast_to_a), .fast_to_b(fast_to_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [DW-1:0] pick(input logic [DW-1:0] m [CELLS], input logic [IW-1:0] i);
        return (int'(i) < CELLS) ? m[i] : '0;
    endfunction

    function automatic logic [DW-1:0] want_a();
        return fast_to_a ? mf : mq_a;
    endfunction

    function automatic logic [DW-1:0] want_b();
        return fast_to_b ? mf : mq_b;
    endfunction

    task automatic model_edge();
        if (rst) begin
            for (int c = 0; c < CELLS; c++) begin ma[c] = '0; mb[c] = '0; end
            mq_a = '0; mq_b = '0; mf = '0;
        end else begin
            mq_a = pick(ma, rd_idx_a);
            mq_b = pick(mb, rd_idx_b);
            if (wr_en_a && int'(wr_idx_a) < CELLS) ma[wr_idx_a] = wr_data;
            if (wr_en_b && int'(wr_idx_b) < CELLS) mb[wr_idx_b] = wr_data;
            if (fast_we) mf = wr_data;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_both(input string req);
        check(req, "opnd_a", opnd_a, want_a());
        check(req, "opnd_b", opnd_b, want_b());
    endtask

    task automatic idle();
        wr_en_a = 0; wr_en_b = 0; fast_we = 0;
    endtask

    task automatic put(input logic ea, input logic eb, input logic [IW-1:0] ia, input logic [IW-1:0] ib, input logic [DW-1:0] d);
        wr_en_a = ea; wr_en_b = eb; wr_idx_a = ia; wr_idx_b = ib; wr_data = d; fast_we = 0;
        tick();
        idle();
    endtask

    task automatic read(input logic [IW-1:0] ia, input logic [IW-1:0] ib);
        rd_idx_a = ia; rd_idx_b = ib;
        tick();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        read(2'd0, 2'd0);
        check("R1", "opnd_a after reset", opnd_a, 8'h00);
        check("R1", "opnd_b after reset", opnd_b, 8'h00);

        // R2: bank A only
        put(1, 0, 2'd1, 2'd1, 8'h3C);
        read(2'd1, 2'd1);
        check("R2", "bank A written", opnd_a, 8'h3C);
        check("R2", "bank B untouched", opnd_b, 8'h00);

        // R3: both banks, different cells
        put(1, 1, 2'd0, 2'd2, 8'hA7);
        read(2'd0, 2'd2);
        check("R3", "bank A cell 0", opnd_a, 8'hA7);
        check("R3", "bank B cell 2", opnd_b, 8'hA7);
        read(2'd2, 2'd0);
        check("R3", "bank A cell 2 unchanged", opnd_a, 8'h00);
        check("R3", "bank B cell 0 unchanged", opnd_b, 8'h00);

        // R5: invalid write index ignored, invalid read gives zero
        put(1, 1, 2'd3, 2'd3, 8'hFF);
        for (int c = 0; c < CELLS; c++) begin
            read(IW'(c), IW'(c));
            check_both("R5");
        end
        read(2'd3, 2'd3);
        check("R5", "bank A read idx 3", opnd_a, 8'h00);
        check("R5", "bank B read idx 3", opnd_b, 8'h00);

        // R6: same-cell write and read returns old value
        rd_idx_a = 2'd0; rd_idx_b = 2'd2;
        put(1, 1, 2'd0, 2'd2, 8'h55);
        check("R6", "bank A old value", opnd_a, 8'hA7);
        check("R6", "bank B old value", opnd_b, 8'hA7);
        read(2'd0, 2'd2);
        check("R6", "bank A new value", opnd_a, 8'h55);

        // R7: fast slot write, visible right after the edge
        fast_to_a = 1; fast_to_b = 0;
        wr_data = 8'h19; fast_we = 1;
        tick();
        fast_we = 0;
        check("R7", "fast on opnd_a", opnd_a, 8'h19);
        check("R9", "bank B still own", opnd_b, 8'h55);

        // R8: combinational route switching
        fast_to_b = 1; #1;
        check("R8", "fast on opnd_b same cycle", opnd_b, 8'h19);
        fast_to_a = 0; #1;
        check("R8", "bank A restored", opnd_a, 8'h55);
        fast_to_b = 0; #1;
        check("R8", "bank B restored", opnd_b, 8'h55);
        @(negedge clk);

        // R4 / R9: random mix
        for (int n = 0; n < 400; n++) begin
            wr_data   = DW'($urandom);
            wr_en_a   = 1'($urandom);
            wr_en_b   = 1'($urandom);
            wr_idx_a  = IW'($urandom);
            wr_idx_b  = IW'($urandom);
            rd_idx_a  = IW'($urandom);
            rd_idx_b  = IW'($urandom);
            fast_we   = ($urandom % 4) == 0;
            fast_to_a = ($urandom % 3) == 0;
            fast_to_b = ($urandom % 3) == 0;
            tick();
            check_both("R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule